// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address with separate write and read strobes. The three lowest addresses reach the count registers of channels 0 to 2. The highest address takes command bytes. The block decodes those bytes into per-channel configuration, count-latch requests and read-back requests. It splits 16-bit count loads into byte writes, and it serves 16-bit counts and status bytes back to the host one byte at a time.

Toward each channel the block drives the operating mode, the byte access mode and the BCD flag. It also drives a one-cycle load strobe together with the 16-bit value to load. From each channel it takes the live count and the output level. The block does no counting itself; the counting logic sits beside it.

A read returns a status byte that is latched and unread ahead of anything else. If no status byte waits, the read returns a latched count, and if nothing is latched it returns the live count. Each channel keeps its own write-side and read-side byte toggle.

Top module: `tmr_host_port`

## Requirements
- R1: After synchronous reset every channel has mode 0, access mode 3 (low byte then high byte) and BCD 0. No count or status is latched, both byte toggles point at the low byte, no load strobe is active and `rdata` is 0.
- R2: A write to address 3 with bits 7:6 = n (0..2) and bits 5:4 nonzero does four things to channel n. It sets the access mode from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high). It sets the mode from bits 3:1, where values 6 and 7 are stored as 2 and 3. It sets BCD from bit 0. It returns both of that channel's byte toggles to the low byte. The new values appear on the configuration outputs in the next cycle.
- R3: A write to address 3 with bits 7:6 = n (0..2) and bits 5:4 = 0 is a counter-latch command: it captures channel n's live count.
- R4: A write of byte b to address n (0..2) loads that channel, with the result depending on access mode. Access mode 1 loads {8'h00, b}. Access mode 2 loads {b, 8'h00}. In access mode 3 the first write only holds b, and the second write c loads {c, held b}. The load strobe of channel n is high for exactly the cycle after the completing write, and at most one load strobe is high at a time.
- R5: A write to address 3 with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 = 0 requests a count latch and bit 4 = 0 requests a status latch. The status byte is {output level, 0, access mode[1:0], mode[2:0], BCD} from bit 7 down to bit 0.
- R6: A count-latch request for a channel whose latched count is still unread changes nothing. A status-latch request for a channel whose status byte is still unread also changes nothing.
- R7: A read of a channel returns a pending status byte first and clears it. Otherwise, if a count is latched, the read returns it per access mode: low byte, high byte, or low then high in mode 3. The latched count is released after its last byte.
- R8: With nothing latched, a read returns the live count: the low byte in access mode 1 and the high byte in access mode 2. In access mode 3 successive reads alternate low and high, starting from the low byte.
- R9: `rdata` is registered. It takes the read byte in the cycle after `rd_en` and holds it while `rd_en` is low. A read of address 3 returns 0 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0..2 channel count, 3 command |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read byte |
| ch_mode | output | 9 | Per-channel mode, 3 bits per channel |
| ch_acc | output | 6 | Per-channel access mode, 2 bits per channel |
| ch_bcd | output | 3 | Per-channel BCD flag |
| ch_load | output | 3 | Per-channel one-cycle count load strobe |
| ch_load_val | output | 48 | Per-channel 16-bit load value |
| ch_count | input | 48 | Per-channel live 16-bit count |
| ch_out | input | 3 | Per-channel output level |

## Verification
Some properties are checked by assertions on every cycle. The stored mode never exceeds 5. A latched count and a latched status byte stay frozen until they are read. A status read empties the status latch without touching the count latch. A load strobe always follows a data write, and at most one is high at a time. `rdata` holds steady between reads. Other behaviour depends on scenarios and is shown by the bench's cycle-level reference model, which covers:
- byte ordering in each access mode;
- ignored repeat latches that return the older value;
- read-back with both latches on several channels;
- toggle reset by a fresh command while a word transfer is half done.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m > 3'd5) ? (m - 3'd4) : m;
  endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:1]        cmd,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] cnt_lat_req,
  output logic [NUM_CH-1:0] sts_lat_req,
  output logic [NUM_CH-1:0] data_we
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = {ADDR_W{1'b1}};

  logic       ctl_wr;
  logic       is_rb;
  logic [1:0] sel;
  logic [1:0] acc_f;

  assign ctl_wr = wr_en && (addr == CTL_ADDR);
  assign sel    = cmd[7:6];
  assign acc_f  = cmd[5:4];
  assign is_rb  = (sel == 2'd3);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit            = !is_rb && (sel == 2'(i));
    assign data_we[i]     = wr_en && (addr == ADDR_W'(i));
    assign cfg_we[i]      = ctl_wr && hit && (acc_f != 2'd0);
    assign cnt_lat_req[i] = ctl_wr && ((hit && (acc_f == 2'd0)) ||
                                       (is_rb && cmd[1+i] && !cmd[5]));
    assign sts_lat_req[i] = ctl_wr && is_rb && cmd[1+i] && !cmd[4];
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cnt_lat_req,
  input  logic              sts_lat_req,
  input  logic              data_we,
  input  logic              rd_hit,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_lvl,
  output logic [MODE_W-1:0] mode,
  output logic [1:0]        acc,
  output logic              bcd,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [MODE_W-1:0] mode_q;
  acc_e              acc_q;
  logic              bcd_q;
  logic              wr_lo_q;
  logic              rd_lo_q;
  logic [BYTE_W-1:0] hold_q;
  acc_e              clat_q;
  logic [CNT_W-1:0]  clat_val;
  logic              slat_v;
  logic [BYTE_W-1:0] slat_byte;
  logic              load_q;
  logic [CNT_W-1:0]  load_val_q;

  // Read byte selection: status, then latched count, then live count.
  always_comb begin
    if (slat_v) begin
      rd_byte = slat_byte;
    end else if (clat_q != ACC_NONE) begin
      rd_byte = (clat_q == ACC_HI) ? clat_val[CNT_W-1:BYTE_W] : clat_val[BYTE_W-1:0];
    end else begin
      unique case (acc_q)
        ACC_HI:   rd_byte = live_count[CNT_W-1:BYTE_W];
        ACC_WORD: rd_byte = rd_lo_q ? live_count[BYTE_W-1:0] : live_count[CNT_W-1:BYTE_W];
        default:  rd_byte = live_count[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      acc_q      <= ACC_WORD;
      bcd_q      <= 1'b0;
      wr_lo_q    <= 1'b1;
      rd_lo_q    <= 1'b1;
      hold_q     <= '0;
      clat_q     <= ACC_NONE;
      clat_val   <= '0;
      slat_v     <= 1'b0;
      slat_byte  <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (rd_hit) begin
        if (slat_v) begin
          slat_v <= 1'b0;
        end else if (clat_q != ACC_NONE) begin
          clat_q <= (clat_q == ACC_WORD) ? ACC_HI : ACC_NONE;
        end else if (acc_q == ACC_WORD) begin
          rd_lo_q <= !rd_lo_q;
        end
      end
      if (cfg_we) begin
        acc_q   <= acc_e'(wdata[5:4]);
        mode_q  <= fold_mode(wdata[3:1]);
        bcd_q   <= wdata[0];
        wr_lo_q <= 1'b1;
        rd_lo_q <= 1'b1;
      end
      if (cnt_lat_req && (clat_q == ACC_NONE)) begin
        clat_q   <= acc_q;
        clat_val <= live_count;
      end
      if (sts_lat_req && !slat_v) begin
        slat_byte <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
        slat_v    <= 1'b1;
      end
      if (data_we) begin
        unique case (acc_q)
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata, {BYTE_W{1'b0}}};
          end
          ACC_WORD: begin
            if (wr_lo_q) begin
              hold_q  <= wdata;
              wr_lo_q <= 1'b0;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata, hold_q};
              wr_lo_q    <= 1'b1;
            end
          end
          default: begin
            load_q     <= 1'b1;
            load_val_q <= {{BYTE_W{1'b0}}, wdata};
          end
        endcase
      end
    end
  end

  assign mode     = mode_q;
  assign acc      = acc_q;
  assign bcd      = bcd_q;
  assign load     = load_q;
  assign load_val = load_val_q;

  // R2: folded mode is always a legal value
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_q <= 3'd5);

  // R6: an unread latched count is frozen
  a_r6_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (clat_q != ACC_NONE) && !rd_hit |=> $stable(clat_val) && (clat_q != ACC_NONE));

  // R6: an unread status byte is frozen
  a_r6_status_frozen: assert property (@(posedge clk) disable iff (rst)
    slat_v && !rd_hit |=> slat_v && $stable(slat_byte));

  // R7: a status read drains only the status latch
  a_r7_status_first: assert property (@(posedge clk) disable iff (rst)
    slat_v && rd_hit && !sts_lat_req && !cnt_lat_req |=> !slat_v && $stable(clat_q));

  // R4: a load strobe follows a data write
  a_r4_load_after_write: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(data_we));
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*BYTE_W-1:0] ch_bytes,
  output logic [BYTE_W-1:0]        rdata
);
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) sel_byte = ch_bytes[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_byte;
  end

  // R9: read data holds between reads
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic                     rd_en,
  output logic [BYTE_W-1:0]        rdata,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH*2-1:0]      ch_acc,
  output logic [NUM_CH-1:0]        ch_bcd,
  output logic [NUM_CH-1:0]        ch_load,
  output logic [NUM_CH*CNT_W-1:0]  ch_load_val,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  input  logic [NUM_CH-1:0]        ch_out
);
  logic [NUM_CH-1:0]        cfg_we;
  logic [NUM_CH-1:0]        cnt_lat_req;
  logic [NUM_CH-1:0]        sts_lat_req;
  logic [NUM_CH-1:0]        data_we;
  logic [NUM_CH*BYTE_W-1:0] ch_bytes;

  tmr_cmd_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en       (wr_en),
    .addr        (addr),
    .cmd         (wdata[7:1]),
    .cfg_we      (cfg_we),
    .cnt_lat_req (cnt_lat_req),
    .sts_lat_req (sts_lat_req),
    .data_we     (data_we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic rd_hit;
    assign rd_hit = rd_en && (addr == ADDR_W'(i));
    tmr_chan_port u_chan (
      .clk         (clk),
      .rst         (rst),
      .cfg_we      (cfg_we[i]),
      .cnt_lat_req (cnt_lat_req[i]),
      .sts_lat_req (sts_lat_req[i]),
      .data_we     (data_we[i]),
      .rd_hit      (rd_hit),
      .wdata       (wdata),
      .live_count  (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl     (ch_out[i]),
      .mode        (ch_mode[i*MODE_W +: MODE_W]),
      .acc         (ch_acc[i*2 +: 2]),
      .bcd         (ch_bcd[i]),
      .load        (ch_load[i]),
      .load_val    (ch_load_val[i*CNT_W +: CNT_W]),
      .rd_byte     (ch_bytes[i*BYTE_W +: BYTE_W])
    );
  end

  tmr_read_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .ch_bytes (ch_bytes),
    .rdata    (rdata)
  );

  // R4: never more than one channel loads in a cycle
  a_r4_single_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_load));
endmodule

// File: tb/tmr_host_port_tb.sv
module tmr_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [8:0]  ch_mode;
  logic [5:0]  ch_acc;
  logic [2:0]  ch_bcd;
  logic [2:0]  ch_load;
  logic [47:0] ch_load_val;
  logic [47:0] ch_count = '0;
  logic [2:0]  ch_out = '0;

  always #4 clk = ~clk;

  tmr_host_port dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .ch_mode(ch_mode), .ch_acc(ch_acc),
    .ch_bcd(ch_bcd), .ch_load(ch_load), .ch_load_val(ch_load_val),
    .ch_count(ch_count), .ch_out(ch_out)
  );

  int nchk = 0;
  int nfail = 0;
  string scen = "reset";

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, scen, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_mode[3], m_acc[3], m_bcd[3], m_wlo[3], m_rlo[3], m_hold[3];
  int m_cst[3], m_cval[3], m_sv[3], m_sb[3];
  string m_ctag[3];
  int e_rdata, e_load, e_lval[3];
  string rtag = "R1 reset rdata";

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_mode[i] = 0; m_acc[i] = 3; m_bcd[i] = 0; m_wlo[i] = 1; m_rlo[i] = 1;
        m_hold[i] = 0; m_cst[i] = 0; m_cval[i] = 0; m_sv[i] = 0; m_sb[i] = 0;
        e_lval[i] = 0;
      end
      e_rdata = 0; e_load = 0;
    end else begin
      e_load = 0;
      if (rd_en) begin
        int a;
        a = int'(addr);
        if (a == 3) begin
          e_rdata = 0; rtag = "R9 command address read";
        end else if (m_sv[a] != 0) begin
          e_rdata = m_sb[a]; m_sv[a] = 0; rtag = "R7 status read first";
        end else if (m_cst[a] != 0) begin
          rtag = m_ctag[a];
          if (m_cst[a] == 2) begin e_rdata = (m_cval[a] >> 8) & 255; m_cst[a] = 0; end
          else if (m_cst[a] == 1) begin e_rdata = m_cval[a] & 255; m_cst[a] = 0; end
          else begin e_rdata = m_cval[a] & 255; m_cst[a] = 2; end
        end else begin
          int lv;
          lv = int'(ch_count[16*a +: 16]);
          rtag = "R8 live read";
          if (m_acc[a] == 1) e_rdata = lv & 255;
          else if (m_acc[a] == 2) e_rdata = (lv >> 8) & 255;
          else begin
            e_rdata = (m_rlo[a] != 0) ? (lv & 255) : ((lv >> 8) & 255);
            m_rlo[a] = 1 - m_rlo[a];
          end
        end
      end
      if (wr_en) begin
        int a, v;
        a = int'(addr); v = int'(wdata);
        if (a == 3) begin
          int s;
          s = v >> 6;
          if (s == 3) begin
            for (int i = 0; i < 3; i++) begin
              if (((v >> (i + 1)) & 1) != 0) begin
                if (((v >> 5) & 1) == 0 && m_cst[i] == 0) begin
                  m_cst[i] = m_acc[i]; m_cval[i] = int'(ch_count[16*i +: 16]);
                  m_ctag[i] = "R5 read-back count";
                end
                if (((v >> 4) & 1) == 0 && m_sv[i] == 0) begin
                  m_sv[i] = 1;
                  m_sb[i] = (int'(ch_out[i]) << 7) | (m_acc[i] << 4) | (m_mode[i] << 1) | m_bcd[i];
                end
              end
            end
          end else if (((v >> 4) & 3) == 0) begin
            if (m_cst[s] == 0) begin
              m_cst[s] = m_acc[s]; m_cval[s] = int'(ch_count[16*s +: 16]);
              m_ctag[s] = "R3 counter latch";
            end
          end else begin
            m_acc[s] = (v >> 4) & 3;
            m_mode[s] = (v >> 1) & 7;
            if (m_mode[s] > 5) m_mode[s] = m_mode[s] - 4;
            m_bcd[s] = v & 1; m_wlo[s] = 1; m_rlo[s] = 1;
          end
        end else begin
          if (m_acc[a] == 1) begin e_load = 1 << a; e_lval[a] = v; end
          else if (m_acc[a] == 2) begin e_load = 1 << a; e_lval[a] = v << 8; end
          else if (m_wlo[a] != 0) begin m_hold[a] = v; m_wlo[a] = 0; end
          else begin e_load = 1 << a; e_lval[a] = (v << 8) | m_hold[a]; m_wlo[a] = 1; end
        end
      end
    end
  end

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (!rst) begin
      chk(rtag, int'(rdata), e_rdata);
      chk("R4 load strobe", int'(ch_load), e_load);
      for (int i = 0; i < 3; i++) begin
        if (ch_load[i]) chk("R4 load value", int'(ch_load_val[16*i +: 16]), e_lval[i]);
        chk("R2 mode", int'(ch_mode[3*i +: 3]), m_mode[i]);
        chk("R2 access", int'(ch_acc[2*i +: 2]), m_acc[i]);
        chk("R2 bcd", int'(ch_bcd[i]), m_bcd[i]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    scen = "R1 reset state";
    chk("R1 access", int'(ch_acc), 6'h3f);
    chk("R1 mode", int'(ch_mode), 0);
    chk("R1 bcd", int'(ch_bcd), 0);
    chk("R1 load", int'(ch_load), 0);
    chk("R1 rdata", int'(rdata), 0);

    ch_count = {16'h0F0E, 16'hABCD, 16'h1234};
    ch_out = 3'b101;

    scen = "R8 live word reads";
    rd(2'd0); rd(2'd0); rd(2'd0);

    scen = "R2 R4 low-byte channel";
    wr(2'd3, 8'h54);
    wr(2'd1, 8'h77);
    rd(2'd1); rd(2'd1);

    scen = "R2 R4 high-byte channel, mode fold";
    wr(2'd3, 8'hAF);
    wr(2'd2, 8'h5A);
    rd(2'd2);

    scen = "R4 word load";
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h22);

    scen = "R3 counter latch";
    wr(2'd3, 8'h00);
    ch_count[15:0] = 16'h9999;
    rd(2'd0); rd(2'd0); rd(2'd0);

    scen = "R6 ignored count latch";
    ch_count[15:0] = 16'h4321;
    wr(2'd3, 8'h00);
    ch_count[15:0] = 16'h5555;
    wr(2'd3, 8'h00);
    rd(2'd0); rd(2'd0);

    scen = "R6 ignored status latch";
    wr(2'd3, 8'hE4);
    ch_out = 3'b111;
    wr(2'd3, 8'hE4);
    rd(2'd1); rd(2'd1);

    scen = "R5 R7 read-back count and status";
    ch_count = {16'hC0DE, 16'hABCD, 16'hBEEF};
    wr(2'd3, 8'hCA);
    ch_count = '0;
    rd(2'd0); rd(2'd0); rd(2'd0); rd(2'd0);
    rd(2'd2); rd(2'd2); rd(2'd2);

    scen = "R2 toggle reset by command";
    ch_count[15:0] = 16'h6A5B;
    rd(2'd0);
    wr(2'd0, 8'h44);
    wr(2'd3, 8'h36);
    rd(2'd0); rd(2'd0);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h02);

    scen = "R9 command address read";
    rd(2'd3);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule